// File: doc/BRIEF.md
# Spread-Spectrum Clock Profile Generator

This block produces the frequency-offset profile that a downstream clock synthesizer uses to spread a pixel clock around its nominal rate. A 3-bit select input either turns spreading off or picks one of seven peak-deviation settings. Each setting is tied to a modulation period of a fixed number of reference clocks. The block outputs a signed deviation word in units of 0.01 %. The word follows a symmetric triangle once per modulation period. Each period starts at zero, rises to +peak, falls through zero to -peak, and returns to zero.

The feature runs only while the low-frequency-mode input is high, which covers the 5 to 20 MHz band. When that input is low, the output is held at zero and the active flag is cleared. A new select value is taken up only when the profile is back at zero at the end of a period, so the synthesizer never sees a step in frequency. When the generator is idle, the new value is taken up on the next clock.

Top module: `ssc_profile_gen`

## Requirements
- R1: With the running select code 000, `dev_o` stays 0 and `active_o` stays 0.
- R2: While `lf_mode_i` is 0, the block is forced idle. From the following clock, `dev_o` is 0 and `active_o` is 0, whatever `sel_i` is. When `lf_mode_i` returns to 1, a new profile starts from phase 0.
- R3: Codes 001, 010, 011 and 100 give peak deviations of 70, 130, 180 and 220. The units are 0.01 % and `dev_o` is two's complement. `dev_o` reaches exactly +peak and -peak in every period.
- R4: Codes 101, 110 and 111 give peak deviations of 70, 120 and 170, reached as +peak and -peak in every period.
- R5: The modulation period is P = 625 reference clocks for codes 001 to 100 and P = 385 for codes 101 to 111.
- R6: Let A = floor(P/4) and let p (0..P-1) be the phase. The magnitude index m is p for p<=A, |2A-p| for A<p<=3A, 4A-p for 3A<p<4A, and 0 for p>=4A. The sign is negative for 2A<p<4A. `dev_o` equals the sign applied to floor(peak*m/A).
- R7: The select code is sampled when the running code is 000 or when the phase is at P-1. At any other time a change of `sel_i` has no effect until that point is reached.
- R8: `active_o` is 1 exactly when the running code is non-zero. The first active cycle shows phase 0, so `dev_o` is 0.
- R9: A synchronous active-high `rst` sets the running code and phase to 0, so `dev_o` is 0 and `active_o` is 0 after the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_i | input | 3 | Deviation/period select code |
| lf_mode_i | input | 1 | Low-frequency-mode enable; 0 forces the block idle |
| dev_o | output | DEV_W | Signed deviation, units of 0.01 % |
| active_o | output | 1 | High while spreading is running |

## Verification
The bench sweeps every select code through whole periods and compares each cycle with a floor-division model. A wrong remainder update in the incremental scaler would shift the triangle by one unit at some phases and would miss the exact crests. Changing the select mid-period targets a design that switches codes at once, which would jump the output and cut the period short. Dropping the mode flag mid-ramp targets a generator that keeps counting or resumes at its old phase instead of restarting at zero. Back-to-back codes with different periods catch a period counter that keeps the old limit for the new code.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

  localparam int CODE_W   = 3;
  localparam int PEAK_MAX = 220;

  typedef logic [CODE_W-1:0] code_t;

  // Peak deviation in units of 0.01 % for each select code
  function automatic int peak_of(input code_t c);
    case (c)
      3'd1:    return 70;
      3'd2:    return 130;
      3'd3:    return 180;
      3'd4:    return 220;
      3'd5:    return 70;
      3'd6:    return 120;
      3'd7:    return 170;
      default: return 0;
    endcase
  endfunction

  // Codes 5..7 use the short modulation period
  function automatic logic short_group(input code_t c);
    return (c >= 3'd5);
  endfunction

  // Triangle magnitude index for phase p with quarter length a
  function automatic int tri_mag(input int p, input int a);
    if (p <= a)           return p;
    else if (p <= 3 * a)  return (p < 2 * a) ? (2 * a - p) : (p - 2 * a);
    else if (p < 4 * a)   return 4 * a - p;
    else                  return 0;
  endfunction

  // Negative half of the triangle
  function automatic logic tri_neg(input int p, input int a);
    return (p > 2 * a) && (p < 4 * a);
  endfunction

endpackage

// File: rtl/ssc_code_map.sv
module ssc_code_map
  import ssc_pkg::*;
#(
  parameter int PERIOD_LONG  = 625,
  parameter int PERIOD_SHORT = 385,
  parameter int PK_W         = 8,
  parameter int PH_W         = 10
) (
  input  code_t           code,
  output logic [PK_W-1:0] peak,
  output logic [PH_W-1:0] quarter,
  output logic [PH_W-1:0] last_ph
);

  localparam int Q_LONG  = PERIOD_LONG / 4;
  localparam int Q_SHORT = PERIOD_SHORT / 4;

  always_comb begin
    peak = PK_W'(peak_of(code));
    if (short_group(code)) begin
      quarter = PH_W'(Q_SHORT);
      last_ph = PH_W'(PERIOD_SHORT - 1);
    end else begin
      quarter = PH_W'(Q_LONG);
      last_ph = PH_W'(PERIOD_LONG - 1);
    end
  end

endmodule

// File: rtl/ssc_phase_seq.sv
module ssc_phase_seq
  import ssc_pkg::*;
#(
  parameter int PH_W = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            lf_en,
  input  code_t           sel,
  input  logic [PH_W-1:0] quarter,
  input  logic [PH_W-1:0] last_ph,
  output code_t           code_q,
  output code_t           code_nxt,
  output logic [PH_W-1:0] mag_cur,
  output logic            restart,
  output logic            step_up,
  output logic            step_dn,
  output logic            neg_nxt
);

  logic [PH_W-1:0] ph_q;
  logic [PH_W-1:0] ph_nxt;
  int              m_now;
  int              m_next;

  always_comb begin
    restart  = 1'b0;
    code_nxt = code_q;
    ph_nxt   = ph_q + 1'b1;
    if (!lf_en) begin
      restart  = 1'b1;
      code_nxt = '0;
      ph_nxt   = '0;
    end else if (code_q == '0 || ph_q == last_ph) begin
      restart  = 1'b1;
      code_nxt = sel;
      ph_nxt   = '0;
    end
    m_now   = tri_mag(int'(ph_q), int'(quarter));
    m_next  = tri_mag(int'(ph_nxt), int'(quarter));
    mag_cur = PH_W'(m_now);
    step_up = !restart && (m_next > m_now);
    step_dn = !restart && (m_next < m_now);
    neg_nxt = !restart && tri_neg(int'(ph_nxt), int'(quarter));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      ph_q   <= '0;
    end else begin
      code_q <= code_nxt;
      ph_q   <= ph_nxt;
    end
  end

  // R5: phase never runs past the end of the running period
  a_r5_phase_range: assert property (@(posedge clk) disable iff (rst)
    ph_q <= last_ph);

  // R7: idle generator sits at phase zero
  a_r7_idle_phase: assert property (@(posedge clk) disable iff (rst)
    (code_q == '0) |-> (ph_q == '0));

  // R7: running code holds until the end of its period
  a_r7_code_hold: assert property (@(posedge clk) disable iff (rst)
    (lf_en && code_q != '0 && ph_q != last_ph) |=> $stable(code_q));

endmodule

// File: rtl/ssc_dda_scale.sv
module ssc_dda_scale #(
  parameter int PK_W  = 8,
  parameter int PH_W  = 10,
  parameter int QW    = 9,
  parameter int RW    = 13,
  parameter int NWRAP = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            up,
  input  logic            dn,
  input  logic [PK_W-1:0] peak,
  input  logic [PH_W-1:0] quarter,
  input  logic [PH_W-1:0] mag_cur,
  output logic [QW-1:0]   q_cur,
  output logic [QW-1:0]   q_nxt
);

  logic signed [RW-1:0] r_q;
  logic signed [RW-1:0] r_n;
  logic signed [RW-1:0] peak_s;
  logic signed [RW-1:0] quart_s;

  assign peak_s  = signed'(RW'(peak));
  assign quart_s = signed'(RW'(quarter));

  // Incremental floor(peak*m/quarter): quotient q, remainder r in [0, quarter)
  always_comb begin
    q_nxt = q_cur;
    r_n   = r_q;
    if (clr) begin
      q_nxt = '0;
      r_n   = '0;
    end else if (up) begin
      r_n = r_q + peak_s;
      for (int i = 0; i < NWRAP; i++) begin
        if (r_n >= quart_s) begin
          r_n   = r_n - quart_s;
          q_nxt = q_nxt + 1'b1;
        end
      end
    end else if (dn) begin
      r_n = r_q - peak_s;
      for (int i = 0; i < NWRAP; i++) begin
        if (r_n < 0) begin
          r_n   = r_n + quart_s;
          q_nxt = q_nxt - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_cur <= '0;
      r_q   <= '0;
    end else begin
      q_cur <= q_nxt;
      r_q   <= r_n;
    end
  end

  // R6: quotient never exceeds the selected peak
  a_r6_quot_bound: assert property (@(posedge clk) disable iff (rst)
    QW'(peak) >= q_cur);

  // R6: remainder stays inside [0, quarter)
  a_r6_rem_range: assert property (@(posedge clk) disable iff (rst)
    (r_q >= 0) && (r_q < quart_s));

  // R6: at a zero magnitude index the scaler is exactly empty
  a_r6_zero_rest: assert property (@(posedge clk) disable iff (rst)
    (mag_cur == '0) |-> (q_cur == '0 && r_q == '0));

endmodule

// File: rtl/ssc_profile_gen.sv
module ssc_profile_gen
  import ssc_pkg::*;
#(
  parameter int PERIOD_LONG  = 625,
  parameter int PERIOD_SHORT = 385,
  parameter int DEV_W        = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [CODE_W-1:0]       sel_i,
  input  logic                    lf_mode_i,
  output logic signed [DEV_W-1:0] dev_o,
  output logic                    active_o
);

  localparam int PH_W    = $clog2(PERIOD_LONG);
  localparam int PK_W    = $clog2(PEAK_MAX + 1);
  localparam int RW      = PH_W + 3;
  localparam int QW      = DEV_W - 1;
  localparam int Q_SHORT = PERIOD_SHORT / 4;
  localparam int NWRAP   = (PEAK_MAX + Q_SHORT - 1) / Q_SHORT;

  code_t           code_q;
  code_t           code_nxt;
  logic [PK_W-1:0] peak;
  logic [PH_W-1:0] quarter;
  logic [PH_W-1:0] last_ph;
  logic [PH_W-1:0] mag_cur;
  logic            restart;
  logic            step_up;
  logic            step_dn;
  logic            neg_nxt;
  logic [QW-1:0]   q_cur;
  logic [QW-1:0]   q_nxt;
  logic signed [DEV_W-1:0] mag_s;

  ssc_code_map #(
    .PERIOD_LONG (PERIOD_LONG),
    .PERIOD_SHORT(PERIOD_SHORT),
    .PK_W        (PK_W),
    .PH_W        (PH_W)
  ) u_map (
    .code   (code_q),
    .peak   (peak),
    .quarter(quarter),
    .last_ph(last_ph)
  );

  ssc_phase_seq #(
    .PH_W(PH_W)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .lf_en   (lf_mode_i),
    .sel     (sel_i),
    .quarter (quarter),
    .last_ph (last_ph),
    .code_q  (code_q),
    .code_nxt(code_nxt),
    .mag_cur (mag_cur),
    .restart (restart),
    .step_up (step_up),
    .step_dn (step_dn),
    .neg_nxt (neg_nxt)
  );

  ssc_dda_scale #(
    .PK_W (PK_W),
    .PH_W (PH_W),
    .QW   (QW),
    .RW   (RW),
    .NWRAP(NWRAP)
  ) u_dda (
    .clk    (clk),
    .rst    (rst),
    .clr    (restart),
    .up     (step_up),
    .dn     (step_dn),
    .peak   (peak),
    .quarter(quarter),
    .mag_cur(mag_cur),
    .q_cur  (q_cur),
    .q_nxt  (q_nxt)
  );

  assign mag_s = signed'({1'b0, q_nxt});

  always_ff @(posedge clk) begin
    if (rst) begin
      dev_o    <= '0;
      active_o <= 1'b0;
    end else begin
      dev_o    <= neg_nxt ? -mag_s : mag_s;
      active_o <= (code_nxt != '0);
    end
  end

  // R2: low mode flag forces the block idle on the next clock
  a_r2_mode_gate: assert property (@(posedge clk) disable iff (rst)
    !lf_mode_i |=> (dev_o == '0 && !active_o));

  // R1: an idle generator emits no deviation
  a_r1_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !active_o |-> (dev_o == '0));

  // R6: consecutive active samples differ by at most NWRAP units
  a_r6_slew: assert property (@(posedge clk) disable iff (rst)
    (active_o && $past(active_o)) |->
      (((DEV_W+1)'(dev_o) - (DEV_W+1)'($past(dev_o)) <= (DEV_W+1)'(NWRAP)) ||
       ((DEV_W+1)'($past(dev_o)) - (DEV_W+1)'(dev_o) <= (DEV_W+1)'(NWRAP))) &&
      ($signed(dev_o) - $signed($past(dev_o)) <= NWRAP) &&
      ($signed($past(dev_o)) - $signed(dev_o) <= NWRAP));

  // R8: first active cycle starts the profile at zero
  a_r8_start_zero: assert property (@(posedge clk) disable iff (rst)
    $rose(active_o) |-> (dev_o == '0));

endmodule

// File: tb/tb_ssc_profile_gen.sv
module tb_ssc_profile_gen;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              lf  = 1'b0;
  logic [2:0]        sel = 3'd0;
  logic signed [9:0] dev;
  logic              act;

  ssc_profile_gen dut (
    .clk      (clk),
    .rst      (rst),
    .sel_i    (sel),
    .lf_mode_i(lf),
    .dev_o    (dev),
    .active_o (act)
  );

  always #4 clk = ~clk;

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 1'b0;
  int    mc     = 0;
  int    mp     = 0;
  string tag    = "R9";

  function automatic int pk(input int c);
    int t[8] = '{0, 70, 130, 180, 220, 70, 120, 170};
    return t[c];
  endfunction

  function automatic int per(input int c);
    return (c >= 5) ? 385 : 625;
  endfunction

  function automatic int expv(input int c, input int p);
    int a, m, v;
    if (c == 0) return 0;
    a = per(c) / 4;
    if (p <= a)          m = p;
    else if (p <= 3 * a) m = (p < 2 * a) ? 2 * a - p : p - 2 * a;
    else if (p < 4 * a)  m = 4 * a - p;
    else                 m = 0;
    v = (pk(c) * m) / a;
    return (p > 2 * a && p < 4 * a) ? -v : v;
  endfunction

  task automatic chk(input string req, input int got, input int want, input string what);
    checks++;
    if (got != want) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d (code=%0d phase=%0d)",
               req, what, got, want, mc, mp);
    end
  endtask

  // Advance the model, clock once, compare outputs
  task automatic step();
    if (rst || !lf) begin
      mc = 0; mp = 0;
    end else if (mc == 0 || mp == per(mc) - 1) begin
      mc = int'(sel); mp = 0;
    end else begin
      mp++;
    end
    @(posedge clk);
    #1;
    chk(tag, int'(dev), expv(mc, mp), "dev");
    chk("R8", int'(act), (mc != 0) ? 1 : 0, "active");
  endtask

  task automatic sweep_code(input int k);
    int t1, t2, mx, mn, len;
    t1 = -1; t2 = -1; mx = -9999; mn = 9999;
    len = 3 * per(k);
    sel = 3'(k);
    tag = "R6";
    for (int n = 0; n < len; n++) begin
      step();
      if (int'(dev) == pk(k)) begin t1 = t2; t2 = n; end
      if (n >= len - per(k)) begin
        if (int'(dev) > mx) mx = int'(dev);
        if (int'(dev) < mn) mn = int'(dev);
      end
    end
    if (k <= 4) begin
      chk("R3", mx, pk(k), "max");
      chk("R3", mn, -pk(k), "min");
    end else begin
      chk("R4", mx, pk(k), "max");
      chk("R4", mn, -pk(k), "min");
    end
    chk("R5", t2 - t1, per(k), "period");
  endtask

  initial begin
    // R9: reset state
    rst = 1'b1;
    tag = "R9";
    repeat (4) step();
    chk("R9", int'(dev), 0, "reset dev");
    chk("R9", int'(act), 0, "reset active");
    rst = 1'b0;

    // R1: enabled but code 000
    lf  = 1'b1;
    sel = 3'd0;
    tag = "R1";
    repeat (700) step();

    // R3, R4, R5, R6: every code in turn
    for (int k = 1; k < 8; k++) sweep_code(k);

    // R7: mid-period select change has no effect until the wrap
    tag = "R7";
    while (mp != 100) step();
    sel = 3'd2;
    step();
    chk("R7", mc, 7, "code kept mid-period");
    repeat (400) step();
    chk("R7", mc, 2, "code taken at wrap");
    tag = "R6";
    repeat (700) step();

    // R2: mode flag low mid-ramp, then restart
    while (mp != 200) step();
    lf  = 1'b0;
    sel = 3'd4;
    tag = "R2";
    repeat (40) step();
    chk("R2", int'(act), 0, "gated active");
    lf  = 1'b1;
    tag = "R6";
    step();
    chk("R2", mp, 0, "restart phase");
    repeat (700) step();

    // R9: synchronous reset mid-run
    while (mp != 300) step();
    rst = 1'b1;
    tag = "R9";
    repeat (3) step();
    rst = 1'b0;
    tag = "R6";
    sel = 3'd6;
    repeat (500) step();

    // R1: back to code 000, taken at the wrap
    sel = 3'd0;
    tag = "R1";
    repeat (800) step();
    chk("R1", int'(act), 0, "off after wrap");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule